// File: doc/BRIEF.md
# Multi-Cycle Hardwired Instruction Sequencer

This block is the control and register core of a small multi-cycle processor. A step counter walks each instruction through a fixed schedule: three fetch steps, one decode step, and up to three execute steps. In each step a hardwired decoder raises a set of register-transfer enables. These enables move words between the program counter, the stack pointer, the memory address and data registers, the instruction register, a sixteen-entry register file and the two adder operand latches. Five instructions are supported: register add, memory load, memory store, branch when the zero flag is set, and subroutine call. Every other opcode is treated as a no-op.

The block reaches memory through one shared port of 256 words of 16 bits. Reads are combinational from the presented address, and the block captures the data into its data register at the end of the read step. Writes commit at the clock edge that ends the write step. The port has a fixed timing and no back-pressure. The enable vector, the current step, the program counter, the stack pointer and the flags are brought out as plain status pins.

Top module: `mcyc_core`

## Requirements
- R1: Instruction word layout is opcode [15:12], register field [11:8], address [7:0]; for add, the two sources are [7:4] and [3:0]. Step 0 copies PC into MAR. Step 1 reads memory at MAR into MDR and increments PC. Step 2 copies MDR into IR.
- R2: Step 3 asserts no enable. Any opcode other than 1 to 5 ends after step 3 and changes nothing except the PC increment from fetch.
- R3: Opcode 1 (add) latches source 1 at step 4 and source 2 at step 5. At step 6 it writes their sum modulo 2^16 to the destination, for seven cycles in all.
- R4: Flags are flags_o[0]=Z (result zero), [1]=C (adder carry out), [2]=V (operands share a sign that the result lacks) and [3]=N (result MSB). They change only at the add result step.
- R5: Opcode 2 (load) moves the address field into MAR at step 4, reads memory into MDR at step 5, and writes MDR to the destination register at step 6.
- R6: Opcode 3 (store) moves the address field into MAR at step 4 and the field-selected register into MDR at step 5. At step 6 it writes MDR to memory at MAR.
- R7: Opcode 4 (branch on zero) ends after step 4. At that step it loads PC with the address field only when Z is 1, and it leaves the flags unchanged.
- R8: Opcode 5 (call) decrements SP at step 4, writes the already-incremented PC to memory at the new SP at step 5, and loads PC with the address field at step 6. SP resets to 0.
- R9: After the last step of an instruction the step counter returns to 0. The step never exceeds 6, and reset puts it at step 0 with PC, SP and flags at 0.
- R10: ctrl_o bits are 0 PC-out, 1 MAR-in, 2 read, 3 write, 4 MDR-in, 5 IR-in, 6 A-in, 7 B-in, 8 ALU-op, 9 register-in, 10 SP decrement, 11 PC load, 12 PC increment. Read and write are never both high, and write occurs only at steps 5 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr_o | output | 8 | Memory address (MAR, or SP during the call push) |
| mem_rd_o | output | 1 | Memory read enable |
| mem_wr_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, valid in the read step |
| ctrl_o | output | 13 | Register-transfer enables of the current step |
| step_o | output | 3 | Current timing step, 0 to 6 |
| pc_o | output | 8 | Program counter |
| sp_o | output | 8 | Stack pointer |
| flags_o | output | 4 | Condition flags {N, V, C, Z} |

## Verification
A step counter that runs ahead or lags shows up at once on step_o and ctrl_o, one cycle after the fault. A wrong decode of the opcode shows within the execute steps of that same instruction, as the wrong enables. A wrong datapath register, such as a stale operand latch, a misrouted MDR source or a bad stack address, shows only when the value reaches memory or the PC. That takes a store or a call, so the bench routes every add result through a store and checks the words it finds in memory, and it checks the flags against values worked out arithmetically.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
  localparam int DW     = 16;
  localparam int AW     = 8;
  localparam int OPW    = 4;
  localparam int RSELW  = 4;
  localparam int NREG   = 1 << RSELW;
  localparam int STEPW  = 3;
  localparam int FLAGW  = 4;

  localparam logic [OPW-1:0] OP_ADD   = 4'd1;
  localparam logic [OPW-1:0] OP_LOAD  = 4'd2;
  localparam logic [OPW-1:0] OP_STORE = 4'd3;
  localparam logic [OPW-1:0] OP_BZ    = 4'd4;
  localparam logic [OPW-1:0] OP_CALL  = 4'd5;

  localparam logic [STEPW-1:0] T0 = 3'd0;
  localparam logic [STEPW-1:0] T1 = 3'd1;
  localparam logic [STEPW-1:0] T2 = 3'd2;
  localparam logic [STEPW-1:0] T3 = 3'd3;
  localparam logic [STEPW-1:0] T4 = 3'd4;
  localparam logic [STEPW-1:0] T5 = 3'd5;
  localparam logic [STEPW-1:0] T6 = 3'd6;

  localparam int C_PC_OUT  = 0;
  localparam int C_MAR_IN  = 1;
  localparam int C_RD      = 2;
  localparam int C_WR      = 3;
  localparam int C_MDR_IN  = 4;
  localparam int C_IR_IN   = 5;
  localparam int C_A_IN    = 6;
  localparam int C_B_IN    = 7;
  localparam int C_ALU_OP  = 8;
  localparam int C_REG_IN  = 9;
  localparam int C_SP_DEC  = 10;
  localparam int C_PC_LOAD = 11;
  localparam int C_PC_INC  = 12;
  localparam int CTRL_W    = 13;

  localparam int F_Z = 0;
  localparam int F_C = 1;
  localparam int F_V = 2;
  localparam int F_N = 3;
endpackage

// File: rtl/mcyc_stepper.sv
module mcyc_stepper
  import mcyc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             last_i,
  output logic [STEPW-1:0] step_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      step_o <= T0;
    else if (last_i) step_o <= T0;
    else             step_o <= step_o + 3'd1;
  end

  a_r9_step_range: assert property (@(posedge clk) disable iff (!rst_n)
    step_o <= T6);
  a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    last_i |=> (step_o == T0));
endmodule

// File: rtl/mcyc_decode.sv
module mcyc_decode
  import mcyc_pkg::*;
(
  input  logic [STEPW-1:0]  step_i,
  input  logic [OPW-1:0]    op_i,
  input  logic              z_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              mdr_src_reg_o,
  output logic              addr_src_sp_o,
  output logic              last_o
);
  logic known_op;
  assign known_op = (op_i == OP_ADD) || (op_i == OP_LOAD) || (op_i == OP_STORE) ||
                    (op_i == OP_BZ)  || (op_i == OP_CALL);

  always_comb begin
    ctrl_o        = '0;
    mdr_src_reg_o = 1'b0;
    addr_src_sp_o = 1'b0;
    last_o        = 1'b0;
    case (step_i)
      T0: begin
        ctrl_o[C_PC_OUT] = 1'b1;
        ctrl_o[C_MAR_IN] = 1'b1;
      end
      T1: begin
        ctrl_o[C_RD]     = 1'b1;
        ctrl_o[C_MDR_IN] = 1'b1;
        ctrl_o[C_PC_INC] = 1'b1;
      end
      T2: ctrl_o[C_IR_IN] = 1'b1;
      T3: last_o = !known_op;
      T4: begin
        case (op_i)
          OP_ADD:   ctrl_o[C_A_IN] = 1'b1;
          OP_LOAD,
          OP_STORE: ctrl_o[C_MAR_IN] = 1'b1;
          OP_BZ: begin
            ctrl_o[C_PC_LOAD] = z_i;
            last_o = 1'b1;
          end
          OP_CALL:  ctrl_o[C_SP_DEC] = 1'b1;
          default:  last_o = 1'b1;
        endcase
      end
      T5: begin
        case (op_i)
          OP_ADD: ctrl_o[C_B_IN] = 1'b1;
          OP_LOAD: begin
            ctrl_o[C_RD]     = 1'b1;
            ctrl_o[C_MDR_IN] = 1'b1;
          end
          OP_STORE: begin
            ctrl_o[C_MDR_IN] = 1'b1;
            mdr_src_reg_o    = 1'b1;
          end
          OP_CALL: begin
            ctrl_o[C_WR]  = 1'b1;
            addr_src_sp_o = 1'b1;
          end
          default: last_o = 1'b1;
        endcase
      end
      T6: begin
        last_o = 1'b1;
        case (op_i)
          OP_ADD: begin
            ctrl_o[C_ALU_OP] = 1'b1;
            ctrl_o[C_REG_IN] = 1'b1;
          end
          OP_LOAD:  ctrl_o[C_REG_IN]  = 1'b1;
          OP_STORE: ctrl_o[C_WR]      = 1'b1;
          OP_CALL:  ctrl_o[C_PC_LOAD] = 1'b1;
          default:  ;
        endcase
      end
      default: last_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/mcyc_alu.sv
module mcyc_alu
  import mcyc_pkg::*;
#(
  parameter int W = DW
)(
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  output logic [W-1:0]     sum_o,
  output logic [FLAGW-1:0] flags_o
);
  logic [W:0] wide;
  assign wide  = {1'b0, a_i} + {1'b0, b_i};
  assign sum_o = wide[W-1:0];

  always_comb begin
    flags_o      = '0;
    flags_o[F_Z] = (wide[W-1:0] == '0);
    flags_o[F_C] = wide[W];
    flags_o[F_V] = (a_i[W-1] == b_i[W-1]) && (wide[W-1] != a_i[W-1]);
    flags_o[F_N] = wide[W-1];
  end
endmodule

// File: rtl/mcyc_datapath.sv
module mcyc_datapath
  import mcyc_pkg::*;
#(
  parameter logic [AW-1:0] SP_INIT = '0
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pc_out_i,
  input  logic             mar_in_i,
  input  logic             mdr_in_i,
  input  logic             mdr_src_reg_i,
  input  logic             ir_in_i,
  input  logic             a_in_i,
  input  logic             b_in_i,
  input  logic             alu_op_i,
  input  logic             reg_in_i,
  input  logic             sp_dec_i,
  input  logic             pc_load_i,
  input  logic             pc_inc_i,
  input  logic             addr_src_sp_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic [OPW-1:0]   op_o,
  output logic             z_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  output logic [AW-1:0]    pc_o,
  output logic [AW-1:0]    sp_o,
  output logic [FLAGW-1:0] flags_o
);
  logic [AW-1:0]    pc_q, sp_q, mar_q;
  logic [DW-1:0]    mdr_q, ir_q, a_q, b_q;
  logic [DW-1:0]    rf_q [NREG];
  logic [FLAGW-1:0] flags_q;
  logic [DW-1:0]    sum;
  logic [FLAGW-1:0] alu_flags;

  logic [RSELW-1:0] f_rd, f_rs1, f_rs2;
  logic [AW-1:0]    f_addr;
  assign op_o   = ir_q[DW-1 -: OPW];
  assign f_rd   = ir_q[DW-OPW-1 -: RSELW];
  assign f_rs1  = ir_q[2*RSELW-1 -: RSELW];
  assign f_rs2  = ir_q[RSELW-1:0];
  assign f_addr = ir_q[AW-1:0];

  mcyc_alu #(.W(DW)) u_alu (
    .a_i(a_q), .b_i(b_q), .sum_o(sum), .flags_o(alu_flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      sp_q    <= SP_INIT;
      mar_q   <= '0;
      mdr_q   <= '0;
      ir_q    <= '0;
      a_q     <= '0;
      b_q     <= '0;
      flags_q <= '0;
    end else begin
      if (mar_in_i)       mar_q <= pc_out_i ? pc_q : f_addr;
      if (mdr_in_i)       mdr_q <= mdr_src_reg_i ? rf_q[f_rd] : mem_rdata_i;
      if (ir_in_i)        ir_q  <= mdr_q;
      if (pc_inc_i)       pc_q  <= pc_q + 1'b1;
      else if (pc_load_i) pc_q  <= f_addr;
      if (sp_dec_i)       sp_q  <= sp_q - 1'b1;
      if (a_in_i)         a_q   <= rf_q[f_rs1];
      if (b_in_i)         b_q   <= rf_q[f_rs2];
      if (alu_op_i)       flags_q <= alu_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) rf_q[k] <= '0;
    end else if (reg_in_i) begin
      rf_q[f_rd] <= alu_op_i ? sum : mdr_q;
    end
  end

  assign mem_addr_o  = addr_src_sp_i ? sp_q : mar_q;
  assign mem_wdata_o = addr_src_sp_i ? {{(DW-AW){1'b0}}, pc_q} : mdr_q;
  assign pc_o        = pc_q;
  assign sp_o        = sp_q;
  assign flags_o     = flags_q;
  assign z_o         = flags_q[F_Z];

  a_r1_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    pc_inc_i |=> (pc_q == $past(pc_q) + 1'b1));
  a_r1_ir_from_mdr: assert property (@(posedge clk) disable iff (!rst_n)
    ir_in_i |=> (ir_q == $past(mdr_q)));
  a_r7_pc_target: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load_i && !pc_inc_i) |=> (pc_q == $past(f_addr)));
  a_r8_sp_predec: assert property (@(posedge clk) disable iff (!rst_n)
    sp_dec_i |=> (sp_q == $past(sp_q) - 1'b1));
  a_r4_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !alu_op_i |=> (flags_q == $past(flags_q)));
endmodule

// File: rtl/mcyc_core.sv
module mcyc_core
  import mcyc_pkg::*;
#(
  parameter logic [AW-1:0] SP_INIT = '0
)(
  input  logic              clk,
  input  logic              rst_n,
  output logic [AW-1:0]     mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [STEPW-1:0]  step_o,
  output logic [AW-1:0]     pc_o,
  output logic [AW-1:0]     sp_o,
  output logic [FLAGW-1:0]  flags_o
);
  logic [STEPW-1:0]  step;
  logic [CTRL_W-1:0] ctrl;
  logic [OPW-1:0]    op;
  logic              z, last, mdr_src_reg, addr_src_sp;

  mcyc_stepper u_stepper (
    .clk(clk), .rst_n(rst_n), .last_i(last), .step_o(step)
  );

  mcyc_decode u_decode (
    .step_i(step), .op_i(op), .z_i(z), .ctrl_o(ctrl),
    .mdr_src_reg_o(mdr_src_reg), .addr_src_sp_o(addr_src_sp), .last_o(last)
  );

  mcyc_datapath #(.SP_INIT(SP_INIT)) u_datapath (
    .clk(clk), .rst_n(rst_n),
    .pc_out_i(ctrl[C_PC_OUT]), .mar_in_i(ctrl[C_MAR_IN]),
    .mdr_in_i(ctrl[C_MDR_IN]), .mdr_src_reg_i(mdr_src_reg),
    .ir_in_i(ctrl[C_IR_IN]), .a_in_i(ctrl[C_A_IN]), .b_in_i(ctrl[C_B_IN]),
    .alu_op_i(ctrl[C_ALU_OP]), .reg_in_i(ctrl[C_REG_IN]),
    .sp_dec_i(ctrl[C_SP_DEC]), .pc_load_i(ctrl[C_PC_LOAD]),
    .pc_inc_i(ctrl[C_PC_INC]), .addr_src_sp_i(addr_src_sp),
    .mem_rdata_i(mem_rdata_i), .op_o(op), .z_o(z),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .pc_o(pc_o), .sp_o(sp_o), .flags_o(flags_o)
  );

  assign mem_rd_o = ctrl[C_RD];
  assign mem_wr_o = ctrl[C_WR];
  assign ctrl_o   = ctrl;
  assign step_o   = step;

  a_r2_decode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (step == T3) |-> (ctrl == '0));
  a_r10_rw_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o));
  a_r10_wr_slot: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> ((step == T5) || (step == T6)));
  a_r3_alu_slot: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[C_ALU_OP] |-> (step == T6));
  a_r10_src_sel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mdr_src_reg, addr_src_sp}));
endmodule

// File: tb/mcyc_core_bench.sv
module mcyc_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mem_addr;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [12:0] ctrl;
  logic [2:0]  step;
  logic [7:0]  pc, sp;
  logic [3:0]  flags;

  logic [15:0] mem [256];
  logic        ld_en = 1'b0;
  logic [7:0]  ld_a = '0;
  logic [15:0] ld_d = '0;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  mcyc_core u_mcyc_core (
    .clk(clk), .rst_n(rst_n), .mem_addr_o(mem_addr), .mem_rd_o(mem_rd),
    .mem_wr_o(mem_wr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .ctrl_o(ctrl), .step_o(step), .pc_o(pc), .sp_o(sp), .flags_o(flags)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) begin
    if (mem_wr)     mem[mem_addr] <= mem_wdata;
    else if (ld_en) mem[ld_a] <= ld_d;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic poke(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_a = a; ld_d = d;
    @(posedge clk);
    #1 ld_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
  endtask

  function automatic logic [15:0] enc(input logic [3:0] op, input logic [3:0] r, input logic [7:0] a);
    return {op, r, a};
  endfunction

  function automatic logic [12:0] exp_ctrl(input int op, input int s, input logic z);
    logic [12:0] c = '0;
    case (s)
      0: c = 13'h0003;
      1: c = 13'h1014;
      2: c = 13'h0020;
      3: c = 13'h0000;
      4: case (op)
           1: c = 13'h0040;
           2, 3: c = 13'h0002;
           4: c = z ? 13'h0800 : 13'h0000;
           5: c = 13'h0400;
           default: c = '0;
         endcase
      5: case (op)
           1: c = 13'h0080;
           2: c = 13'h0014;
           3: c = 13'h0010;
           5: c = 13'h0008;
           default: c = '0;
         endcase
      6: case (op)
           1: c = 13'h0300;
           2: c = 13'h0200;
           3: c = 13'h0008;
           5: c = 13'h0800;
           default: c = '0;
         endcase
      default: c = '0;
    endcase
    return c;
  endfunction

  // walks one instruction: checks step number and enables in every step (R10, R9)
  task automatic run_instr(input int op, input logic z, input string req);
    int len;
    if (op >= 1 && op <= 5) len = (op == 4) ? 5 : 7;
    else len = 4;
    for (int s = 0; s < len; s++) begin
      chk(req, step, s);
      chk("R10", ctrl, exp_ctrl(op, s, z));
      tick(1);
    end
    chk("R9", step, 0);
  endtask

  function automatic logic [15:0] pick(input int i);
    case (i)
      0: return 16'h0000;  1: return 16'h0001;  2: return 16'h0002;  3: return 16'h7FFF;
      4: return 16'h8000;  5: return 16'h8001;  6: return 16'hFFFF;  7: return 16'hFFFE;
      8: return 16'h1234;  9: return 16'h00FF; 10: return 16'h4000; 11: return 16'hC000;
      12: return 16'h7FFE; 13: return 16'h5555; 14: return 16'hAAAA; default: return 16'h0F0F;
    endcase
  endfunction

  function automatic logic [3:0] exp_flags(input logic [15:0] x, input logic [15:0] y);
    logic [16:0] w = {1'b0, x} + {1'b0, y};
    logic [15:0] r = w[15:0];
    return {r[15], (x[15] == y[15]) && (r[15] != x[15]), w[16], r == 16'h0000};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // reset state (R9)
    tick(2);
    chk("R9", step, 0);
    chk("R9", pc, 0);
    chk("R8", sp, 0);
    chk("R9", flags, 0);
    chk("R1", ctrl, 13'h0003);

    // add sweep through load and store: R1 R3 R4 R5 R6
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        logic [15:0] x = pick(i);
        logic [15:0] y = pick(j);
        poke(8'h00, enc(4'd2, 4'd1, 8'h80));
        poke(8'h01, enc(4'd2, 4'd2, 8'h81));
        poke(8'h02, {4'd1, 4'd3, 4'd1, 4'd2});
        poke(8'h03, enc(4'd3, 4'd3, 8'h82));
        poke(8'h80, x);
        poke(8'h81, y);
        poke(8'h82, 16'hDEAD);
        do_reset();
        run_instr(2, 1'b0, "R5");
        chk("R1", pc, 1);
        run_instr(2, 1'b0, "R5");
        run_instr(1, 1'b0, "R3");
        chk("R4", flags, exp_flags(x, y));
        run_instr(3, 1'b0, "R6");
        chk("R6", mem[8'h82], x + y);
        chk("R4", flags, exp_flags(x, y));
        chk("R1", pc, 4);
      end
    end

    // branch on zero, taken and not taken (R7)
    for (int k = 0; k < 3; k++) begin
      logic [15:0] x = (k == 0) ? 16'h0000 : (k == 1) ? 16'hFFFF : 16'h0001;
      logic [15:0] y = (k == 0) ? 16'h0000 : 16'h0001;
      logic [3:0]  f = exp_flags(x, y);
      poke(8'h00, enc(4'd2, 4'd1, 8'h80));
      poke(8'h01, enc(4'd2, 4'd2, 8'h81));
      poke(8'h02, {4'd1, 4'd3, 4'd1, 4'd2});
      poke(8'h03, enc(4'd4, 4'd0, 8'h30));
      poke(8'h80, x);
      poke(8'h81, y);
      do_reset();
      run_instr(2, 1'b0, "R5");
      run_instr(2, 1'b0, "R5");
      run_instr(1, 1'b0, "R3");
      run_instr(4, f[0], "R7");
      chk("R7", pc, f[0] ? 8'h30 : 8'h04);
      chk("R7", flags, f);
    end

    // undefined opcodes are no-ops ending after step 3 (R2)
    poke(8'h00, 16'hF123);
    poke(8'h01, 16'h0ABC);
    poke(8'h02, enc(4'd3, 4'd1, 8'h90));
    poke(8'h90, 16'hBEEF);
    do_reset();
    run_instr(15, 1'b0, "R2");
    chk("R2", pc, 1);
    run_instr(0, 1'b0, "R2");
    chk("R2", pc, 2);
    chk("R2", flags, 0);
    run_instr(3, 1'b0, "R6");
    chk("R2", mem[8'h90], 16'h0000);

    // nested calls with pre-decremented stack pointer (R8)
    poke(8'h00, enc(4'd5, 4'd7, 8'h40));
    poke(8'h40, enc(4'd5, 4'd0, 8'h60));
    poke(8'hFF, 16'h1111);
    poke(8'hFE, 16'h2222);
    do_reset();
    run_instr(5, 1'b0, "R8");
    chk("R8", pc, 8'h40);
    chk("R8", sp, 8'hFF);
    chk("R8", mem[8'hFF], 16'h0001);
    run_instr(5, 1'b0, "R8");
    chk("R8", pc, 8'h60);
    chk("R8", sp, 8'hFE);
    chk("R8", mem[8'hFE], 16'h0041);
    chk("R8", flags, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule